// File: doc/BRIEF.md
# Serial EEPROM Command and Read Front End

This block is the slave side of a serial-peripheral bus for a 1024-byte nonvolatile memory model. It accepts bus modes 0 and 3, takes an 8-bit instruction and a 16-bit address field (of which the low 10 bits select a byte), and recognises six instructions. Read instructions stream bytes back on the serial output. Reads of the array advance the address by one per byte and wrap from the top of the array to the bottom. Status reads repeat the status byte for as long as the clock runs. A hold input pauses the transfer on any bit and lets it resume on the same bit.

The block oversamples the serial clock, chip select, hold and data input on a fast system clock. Each of these inputs passes through two synchronizer flops and an edge detector. Write-type instructions are not committed here. Each completed byte that a write controller needs is issued as a one-cycle beat carrying the opcode, the address and the data. That controller owns the enable latch, the protection checks and the commit timing. It owns the status byte and returns it through a plain input. It updates the byte array through a plain write port. The outgoing beat is valid-only. It has no ready and no back-pressure. Beats are at least eight serial clocks apart, and the receiver must take every beat in the cycle it appears.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, every array byte reads 0xFF. `so_oe` is 0 whenever `cs_n` has been high for three system clocks.
- R2: The instruction byte is taken at the rising edge of serial clock index 7, counted from 0 after `cs_n` falls. A select that ends after seven or fewer rising edges produces no beat.
- R3: Opcode 0x06 or 0x04 produces exactly one beat with `wr_op` equal to the opcode and with `wr_addr` and `wr_data` both 0.
- R4: After opcode 0x03 and the 16-bit address field, the addressed byte is driven MSB first. D7 is driven from the falling edge of clock index 23. The upper 6 field bits are ignored, and `so_oe` stays 0 during the instruction and address bits.
- R5: While the serial clock keeps running after a read, each following byte comes from the next address. The address after 0x3FF is 0x000.
- R6: Opcode 0x02 produces one beat for each complete data byte that follows the address field. The beat address keeps the upper 5 address bits and adds the byte count to the low 5 bits modulo 32.
- R7: Opcode 0x01 produces exactly one beat, with `wr_data` equal to the byte clocked in at indices 8 to 15. Any further bytes are ignored.
- R8: Opcode 0x05 drives `status_in` with bits 6, 5 and 4 forced to 0, starting at the falling edge of clock index 7. The byte repeats for as long as the clock runs.
- R9: Any other opcode produces no beat and keeps `so_oe` at 0 until `cs_n` goes high.
- R10: While `hold_n` is low, serial clock edges and `si` are ignored and `so_oe` is 0. Releasing `hold_n` while the serial clock is low resumes the transfer on the pending bit.
- R11: Raising `cs_n` while `hold_n` is low abandons the command. The next select starts decoding from bit 0.
- R12: `wr_valid` is never high for two consecutive cycles, and it is high only with opcodes 0x06, 0x04, 0x02 or 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on rising serial clock |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out, changed after falling serial clock |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| status_in | input | 8 | Status byte supplied by the write controller |
| wr_valid | output | 1 | One-cycle beat to the write controller, no back-pressure |
| wr_op | output | 8 | Opcode of the beat |
| wr_addr | output | 10 | Byte address of the beat |
| wr_data | output | 8 | Data byte of the beat |
| mem_we | input | 1 | Array write strobe from the write controller |
| mem_waddr | input | 10 | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The main read path is exercised in three ways, each of which shows up a different fault:
- An unwritten array is read first, which shows whether the reset contents are correct.
- A single continuous read of 1040 bytes starts eight bytes below the top of the array, with the upper field bits set. This separates a wrong increment, a missing wrap and a wrong address mask.
- Reads interrupted by hold, both inside the address field and inside a data byte, show whether any bit is lost or repeated.

Write-type instructions are checked by recording every beat. The page test starts three bytes below a page boundary, so a full-width carry and a page wrap produce different beat addresses. Short, unknown and abandoned selects must leave the beat count unchanged.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } opcode_e;

  localparam logic [7:0] STAT_MASK = 8'h8F;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q      = s2;
  assign q_prev = s3;
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arr[g] <= INIT;
      else if (we && waddr == ADDR_W'(g)) arr[g] <= wdata;
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
  import spi_ee_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned PAGE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              si,
  output logic              req_valid,
  output logic [7:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              fetch,
  output logic              fetch_stat,
  output logic [ADDR_W-1:0] rd_ptr
);
  localparam int unsigned HDR = 8 + FIELD_W;
  localparam int unsigned TOP = HDR + 7;
  localparam int unsigned CW  = $clog2(TOP + 1);

  logic [CW-1:0]      cnt;
  logic [FIELD_W-1:0] sr;
  logic [7:0]         op;
  logic [ADDR_W-1:0]  base;
  logic [PAGE_W-1:0]  offs;
  logic [FIELD_W-1:0] field;
  logic [7:0]         nb;
  logic               at_op, at_hdr, at_byte, past_hdr;

  always_comb begin
    field    = {sr[FIELD_W-2:0], si};
    nb       = field[7:0];
    at_op    = (cnt == CW'(7));
    at_hdr   = (cnt == CW'(HDR - 1));
    at_byte  = (cnt[2:0] == 3'b111);
    past_hdr = (cnt > CW'(HDR - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sr <= '0; op <= '0; base <= '0; offs <= '0;
      req_valid <= 1'b0; req_op <= '0; req_addr <= '0; req_data <= '0;
      fetch <= 1'b0; fetch_stat <= 1'b0; rd_ptr <= '0;
    end else begin
      req_valid <= 1'b0;
      fetch     <= 1'b0;
      if (clr) begin
        cnt  <= '0;
        op   <= '0;
        offs <= '0;
      end else if (rise) begin
        sr  <= field;
        cnt <= (cnt == CW'(TOP)) ? CW'(HDR) : cnt + 1'b1;
        if (at_op) begin
          op <= nb;
          if (nb == OP_WREN || nb == OP_WRDI) begin
            req_valid <= 1'b1; req_op <= nb; req_addr <= '0; req_data <= '0;
          end
          if (nb == OP_RDSR) begin
            fetch <= 1'b1; fetch_stat <= 1'b1;
          end
        end
        if (op == OP_RDSR && at_byte && !at_op) begin
          fetch <= 1'b1; fetch_stat <= 1'b1;
        end
        if (op == OP_WRSR && cnt == CW'(15)) begin
          req_valid <= 1'b1; req_op <= op; req_addr <= '0; req_data <= nb;
        end
        if (at_hdr) begin
          base <= field[ADDR_W-1:0];
          if (op == OP_READ) begin
            rd_ptr <= field[ADDR_W-1:0]; fetch <= 1'b1; fetch_stat <= 1'b0;
          end
        end
        if (op == OP_READ && at_byte && past_hdr) begin
          rd_ptr <= rd_ptr + 1'b1; fetch <= 1'b1; fetch_stat <= 1'b0;
        end
        if (op == OP_WRITE && at_byte && past_hdr) begin
          req_valid <= 1'b1;
          req_op    <= op;
          req_addr  <= {base[ADDR_W-1:PAGE_W], base[PAGE_W-1:0] + offs};
          req_data  <= nb;
          offs      <= offs + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_ee_tx.sv
module spi_ee_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       fall,
  input  logic       fetch,
  input  logic [7:0] byte_in,
  output logic       so,
  output logic       active
);
  logic       pend;
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; sh <= '0; so <= 1'b0; active <= 1'b0;
    end else if (clr) begin
      pend <= 1'b0; so <= 1'b0; active <= 1'b0;
    end else begin
      if (fetch) pend <= 1'b1;
      if (fall) begin
        if (pend) begin
          sh     <= {byte_in[6:0], 1'b0};
          so     <= byte_in[7];
          active <= 1'b1;
          pend   <= 1'b0;
        end else if (active) begin
          so <= sh[7];
          sh <= {sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
  import spi_ee_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned PAGE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic [7:0]        status_in,
  output logic              wr_valid,
  output logic [7:0]        wr_op,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata
);
  localparam int unsigned IX_SI = 0, IX_SCK = 1, IX_CS = 2, IX_HOLD = 3;

  logic [3:0] lvl, prv;
  logic       live, rise, fall, clr;
  logic       fetch, fetch_stat, tx_act;
  logic [ADDR_W-1:0] rd_ptr;
  logic [7:0] mem_q, tx_byte;

  spi_ee_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hold_n, cs_n, sck, si}), .q(lvl), .q_prev(prv)
  );

  always_comb begin
    clr  = lvl[IX_CS];
    live = !lvl[IX_CS] && lvl[IX_HOLD];
    rise = live && lvl[IX_SCK] && !prv[IX_SCK];
    fall = live && !lvl[IX_SCK] && prv[IX_SCK];
  end

  spi_ee_cmd #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .PAGE_W(PAGE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise), .si(lvl[IX_SI]),
    .req_valid(wr_valid), .req_op(wr_op), .req_addr(wr_addr), .req_data(wr_data),
    .fetch(fetch), .fetch_stat(fetch_stat), .rd_ptr(rd_ptr)
  );

  spi_ee_mem #(.ADDR_W(ADDR_W), .DATA_W(8), .INIT(8'hFF)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_ptr), .rdata(mem_q)
  );

  assign tx_byte = fetch_stat ? (status_in & STAT_MASK) : mem_q;

  spi_ee_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fall(fall), .fetch(fetch),
    .byte_in(tx_byte), .so(so), .active(tx_act)
  );

  assign so_oe = tx_act && live;
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_oe,
  input logic       wr_valid,
  input logic [7:0] wr_op
);
  // R1
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe);

  // R12
  beat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R12
  beat_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_op == 8'h06 || wr_op == 8'h04 || wr_op == 8'h02 || wr_op == 8'h01));

  // R9
  beat_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !so_oe);
endmodule

bind spi_eeprom_engine spi_ee_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
  .so_oe(so_oe), .wr_valid(wr_valid), .wr_op(wr_op)
);

// File: tb/tb_spi_eeprom_engine.sv
module tb_spi_eeprom_engine;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic so, so_oe;
  logic [7:0] status_in = 8'h00;
  logic wr_valid;
  logic [7:0] wr_op, wr_data;
  logic [9:0] wr_addr;
  logic mem_we = 0;
  logic [9:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_eeprom_engine dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .status_in(status_in),
    .wr_valid(wr_valid), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  // beat recorder
  int         nb = 0;
  bit         dbl = 0;
  logic       last_v = 0;
  logic [7:0] r_op [32];
  logic [9:0] r_ad [32];
  logic [7:0] r_dt [32];
  always @(posedge clk) begin
    last_v <= wr_valid;
    if (wr_valid && last_v) dbl <= 1;
    if (wr_valid) begin
      if (nb < 32) begin
        r_op[nb] <= wr_op; r_ad[nb] <= wr_addr; r_dt[nb] <= wr_data;
      end
      nb <= nb + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 5)) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    o = so; oe = so_oe;
    sck = 1;
    repeat (HALF) @(negedge clk);
    sck = 0;
  endtask

  bit oe_seen;
  task automatic sendn(input logic [31:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(v[i], o, oe);
      if (oe) oe_seen = 1;
    end
  endtask

  task automatic rbyte(output logic [7:0] d);
    logic o, oe;
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b0, o, oe);
      d[i] = o;
      if (!oe) d[i] = 1'bx;
    end
  endtask

  task automatic sel;
    cs_n = 0; oe_seen = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel;
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int b0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(so_oe == 0, "R1 oe after reset", so_oe, 0);
    chk(nb == 0, "R1 no beats after reset", nb, 0);

    // R1 R4 unwritten byte, upper field bits set
    sel; sendn(8'h03, 8); sendn(16'hA805, 16);
    chk(oe_seen == 0, "R4 oe low during header", oe_seen, 0);
    rbyte(d); desel;
    chk(d === 8'hFF, "R1 reset contents", d, 8'hFF);
    chk(so_oe == 0, "R1 oe low after deselect", so_oe, 0);

    // preload through the controller port
    for (int a = 0; a < 1024; a++) begin
      mem_we = 1; mem_waddr = 10'(a); mem_wdata = pat(a);
      @(negedge clk);
    end
    mem_we = 0;

    // R4 R5 continuous read across the wrap, upper field bits ignored
    sel; sendn(8'h03, 8); sendn(16'hFFF8, 16);
    for (int i = 0; i < 1040; i++) begin
      int a;
      a = (16'h3F8 + i) & 10'h3FF;
      rbyte(d);
      chk(d === pat(a), i == 0 ? "R4 first byte" : "R5 auto increment/wrap", d, pat(a));
    end
    desel;

    // R3 enable / disable
    b0 = nb;
    sel; sendn(8'h06, 8); desel;
    sel; sendn(8'h04, 8); desel;
    chk(nb == b0 + 2, "R3 beat count", nb - b0, 2);
    chk(r_op[b0] == 8'h06 && r_ad[b0] == 0 && r_dt[b0] == 0, "R3 enable beat", r_op[b0], 8'h06);
    chk(r_op[b0+1] == 8'h04, "R3 disable beat", r_op[b0+1], 8'h04);

    // R2 seven clocks only
    b0 = nb;
    sel; sendn(7'b0000011, 7); desel;
    chk(nb == b0, "R2 short select ignored", nb - b0, 0);

    // R9 unknown opcode
    sel; sendn(8'hA5, 8); sendn(24'hFFFFFF, 24); desel;
    chk(nb == b0 && oe_seen == 0, "R9 unknown opcode ignored", nb - b0, 0);

    // R6 page write wrapping inside the page
    b0 = nb;
    sel; sendn(8'h02, 8); sendn(16'h03FD, 16);
    sendn(8'h11, 8); sendn(8'h22, 8); sendn(8'h33, 8); sendn(8'h44, 8); desel;
    chk(nb == b0 + 4, "R6 beat count", nb - b0, 4);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = 10'h3E0 | ((5'h1D + k) & 5'h1F);
      chk(r_op[b0+k] == 8'h02 && r_ad[b0+k] == 10'(ea) && r_dt[b0+k] == 8'(17 * (k + 1)),
          "R6 page beat", r_ad[b0+k], ea);
    end

    // R7 status write, extra byte ignored
    b0 = nb;
    sel; sendn(8'h01, 8); sendn(8'h8C, 8); sendn(8'h55, 8); desel;
    chk(nb == b0 + 1, "R7 single beat", nb - b0, 1);
    chk(r_op[b0] == 8'h01 && r_dt[b0] == 8'h8C, "R7 status byte", r_dt[b0], 8'h8C);

    // R8 status read, masked and repeated
    status_in = 8'hFF;
    sel; sendn(8'h05, 8); rbyte(d); rbyte(d2); desel;
    chk(d === 8'h8F && d2 === 8'h8F, "R8 status 0xFF", {d, d2}, 16'h8F8F);
    status_in = 8'h72;
    sel; sendn(8'h05, 8); rbyte(d); desel;
    chk(d === 8'h02, "R8 status 0x72", d, 8'h02);

    // R10 hold inside the address field and inside a data byte
    sel; sendn(8'h03, 8); sendn(5'b00000, 5);
    repeat (HALF) @(negedge clk);
    hold_n = 0;
    repeat (HALF) @(negedge clk);
    for (int w = 0; w < 3; w++) begin
      si = 1; sck = 1; repeat (HALF) @(negedge clk);
      chk(so_oe == 0, "R10 oe low in hold", so_oe, 0);
      sck = 0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1;
    sendn(11'h010, 11);
    rbyte(d);
    chk(d === pat(16), "R10 resume in address", d, pat(16));
    begin
      logic o, oe;
      for (int i = 7; i >= 4; i--) begin sbit(1'b0, o, oe); d[i] = oe ? o : 1'bx; end
      repeat (HALF) @(negedge clk);
      hold_n = 0;
      repeat (HALF) @(negedge clk);
      sck = 1; repeat (HALF) @(negedge clk);
      chk(so_oe == 0, "R10 oe low in data hold", so_oe, 0);
      sck = 0; repeat (HALF) @(negedge clk);
      hold_n = 1;
      for (int i = 3; i >= 0; i--) begin sbit(1'b0, o, oe); d[i] = oe ? o : 1'bx; end
    end
    desel;
    chk(d === pat(17), "R10 resume in data", d, pat(17));

    // R11 deselect during hold abandons the command
    b0 = nb;
    sel; sendn(4'b0000, 4);
    repeat (HALF) @(negedge clk);
    hold_n = 0;
    repeat (2 * HALF) @(negedge clk);
    cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
    hold_n = 1;
    repeat (2 * HALF) @(negedge clk);
    chk(nb == b0, "R11 no beat after abort", nb - b0, 0);
    sel; sendn(8'h04, 8); desel;
    chk(nb == b0 + 1 && r_op[b0] == 8'h04, "R11 fresh decode", r_op[b0], 8'h04);

    // R12 beats single-cycle
    chk(dbl == 0, "R12 single-cycle beats", dbl, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule